// File: doc/BRIEF.md
# Designated-Pointer Register File with Interrupt Entry

This block holds sixteen 16-bit scratchpad registers and two 4-bit designators. One designator picks which register acts as the program counter and the other picks the data pointer. The choice is made at run time, so any register can serve either role. The block also holds an 8-bit context latch and an interrupt-enable bit. The processor core around it decodes nothing for it: the core presents an opcode byte with a valid strobe, and the block carries out the register-class operations in one cycle. These are increment, decrement, byte get and put through an 8-bit data path, selecting the program-counter register and selecting the data-pointer register.

The block also performs the context operations that move the packed designator pair {data-pointer select, program-counter select} through a byte-wide memory port. The memory port has a combinational read. These operations are push-mark, save-latch, return and return-with-disable. In an idle cycle with interrupts enabled, a pending interrupt request is taken: the current designators go into the context latch, the program counter becomes register 1, the data pointer becomes register 2, and further interrupts are masked. No program counter value is pushed.

Top module: `dsg_regfile`

## Requirements
- R1: After reset, both designators are 0, interrupts are enabled, and all sixteen registers read 0. So `pc_addr`, `dp_addr`, `sel_p` and `sel_x` read 0 and `ie` reads 1.
- R2: Opcode 0x1N adds one to register N and opcode 0x2N subtracts one from it, both modulo 2^16. Opcode 0x60 adds one to the register chosen by the data-pointer select.
- R3: Opcode 0x8N drives bits 7:0 of register N on `d_out`, and opcode 0x9N drives bits 15:8. In both cases `d_out_vld` is high in the same cycle; it is low for every other opcode.
- R4: Opcode 0xAN writes `d_in` into bits 7:0 of register N, and opcode 0xBN writes it into bits 15:8. The other byte is kept.
- R5: Opcode 0xDN sets the program-counter select to N, and opcode 0xEN sets the data-pointer select to N. `pc_addr` and `dp_addr` always show the contents of the selected registers.
- R6: Opcode 0x79 (mark) does four things. It writes the byte {sel_x, sel_p} (data-pointer select in bits 7:4) to memory at the address in register 2. It copies the same byte into the context latch. It sets the data-pointer select equal to the program-counter select. It decrements register 2.
- R7: Opcodes 0x70 and 0x71 read a byte from memory at the address in the data-pointer register. Bits 7:4 of that byte become the data-pointer select and bits 3:0 become the program-counter select. The data-pointer register that was used for the read is then incremented. 0x70 sets `ie` and 0x71 clears it.
- R8: Opcode 0x78 writes the context latch to memory at the address in the data-pointer register.
- R9: When `irq_req` is high, `ie` is 1 and `op_valid` is low, `irq_ack` pulses for that cycle. On the next edge the latch takes {sel_x, sel_p}, the program-counter select becomes 1, the data-pointer select becomes 2, and `ie` clears.
- R10: A request made while `ie` is 0, or in a cycle with `op_valid` high, is not taken: it changes no designator and gives no acknowledge. A request still held when `ie` is set again is taken in the next idle cycle.
- R11: Every opcode not listed above, including 0x0N, 0x61–0x6F, 0x72–0x77, 0x7A–0x7F, 0xC?, 0xF?, leaves all registers, designators, `ie` and the latch unchanged and makes no memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Opcode present this cycle |
| op_code | input | 8 | Opcode byte |
| d_in | input | 8 | Byte to be written by the put-byte opcodes |
| d_out | output | 8 | Byte read by the get-byte opcodes |
| d_out_vld | output | 1 | `d_out` carries a get-byte result |
| irq_req | input | 1 | Level interrupt request |
| irq_ack | output | 1 | Interrupt taken this cycle |
| mem_addr | output | 16 | Memory address for context transfers |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_wdata | output | 8 | Memory write byte |
| mem_rdata | input | 8 | Memory read byte, valid in the same cycle |
| pc_addr | output | 16 | Contents of the program-counter register |
| dp_addr | output | 16 | Contents of the data-pointer register |
| sel_p | output | 4 | Program-counter select |
| sel_x | output | 4 | Data-pointer select |
| ie | output | 1 | Interrupt enable |

## Verification
Directed sequences load registers through the put-byte opcodes with values chosen so that a carry from the low byte (0x12FF) and a wrap in both directions (0xFFFF up, 0x0000 down) appear. A swapped or missing byte lane, or a truncated carry, shows up there. Select changes that are followed by increments of the data pointer show whether the operand comes from the field N or from a designator. Mark, save and the two return forms are run with the program-counter and data-pointer selects set to distinct values, so a swapped nibble order shows up. Interrupt requests are held across an issued opcode, across a masked period and across the return that unmasks them, which separates a correct acceptance rule from one that ignores `ie` or `op_valid`. A long run of random opcodes, data and requests then compares every output with the reference model on every cycle.

// File: rtl/dsg_pkg.sv
package dsg_pkg;
  typedef enum logic [3:0] {
    K_NONE, K_INC, K_DEC, K_INCX, K_GETLO, K_GETHI, K_PUTLO, K_PUTHI,
    K_SELP, K_SELX, K_MARK, K_RETE, K_RETD, K_SAVE
  } op_kind_e;
endpackage

// File: rtl/dsg_decode.sv
module dsg_decode
  import dsg_pkg::*;
#(
  parameter int OPW  = 8,
  parameter int SELW = 4
) (
  input  logic            op_valid,
  input  logic [OPW-1:0]  op_code,
  output op_kind_e        kind,
  output logic [SELW-1:0] fld_n
);
  logic [OPW-SELW-1:0] grp;

  assign grp   = op_code[OPW-1:SELW];
  assign fld_n = op_code[SELW-1:0];

  always_comb begin
    kind = K_NONE;
    if (op_valid) begin
      unique case (grp)
        'h1: kind = K_INC;
        'h2: kind = K_DEC;
        'h6: if (fld_n == '0) kind = K_INCX;
        'h7: begin
          case (fld_n)
            'h0: kind = K_RETE;
            'h1: kind = K_RETD;
            'h8: kind = K_SAVE;
            'h9: kind = K_MARK;
            default: kind = K_NONE;
          endcase
        end
        'h8: kind = K_GETLO;
        'h9: kind = K_GETHI;
        'hA: kind = K_PUTLO;
        'hB: kind = K_PUTHI;
        'hD: kind = K_SELP;
        'hE: kind = K_SELX;
        default: kind = K_NONE;
      endcase
    end
  end
endmodule

// File: rtl/dsg_bank.sv
module dsg_bank #(
  parameter int NREG = 16,
  parameter int RW   = 16,
  parameter int NRD  = 4,
  localparam int IDXW = $clog2(NREG)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [IDXW-1:0]            wr_idx,
  input  logic [RW-1:0]              wr_val,
  input  logic [NRD-1:0][IDXW-1:0]   rd_idx,
  output logic [NRD-1:0][RW-1:0]     rd_val
);
  logic [RW-1:0] reg_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic hit;
    assign hit = wr_en && (wr_idx == IDXW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   reg_q[g] <= '0;
      else if (hit) reg_q[g] <= wr_val;
    end
  end

  for (genvar k = 0; k < NRD; k++) begin : g_rd
    assign rd_val[k] = reg_q[rd_idx[k]];
  end
endmodule

// File: rtl/dsg_ctrl.sv
module dsg_ctrl
  import dsg_pkg::*;
#(
  parameter int SELW = 4,
  parameter int DW   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  input  op_kind_e        kind,
  input  logic [SELW-1:0] fld_n,
  input  logic            irq_req,
  input  logic [DW-1:0]   mem_rdata,
  output logic [SELW-1:0] p_q,
  output logic [SELW-1:0] x_q,
  output logic [DW-1:0]   t_q,
  output logic            ie_q,
  output logic            irq_ack
);
  logic [SELW-1:0] p_d, x_d;
  logic [DW-1:0]   t_d;
  logic            ie_d;

  assign irq_ack = irq_req && ie_q && !op_valid;

  always_comb begin
    p_d  = p_q;
    x_d  = x_q;
    t_d  = t_q;
    ie_d = ie_q;
    if (irq_ack) begin
      t_d  = DW'({x_q, p_q});
      p_d  = SELW'(1);
      x_d  = SELW'(2);
      ie_d = 1'b0;
    end else begin
      case (kind)
        K_SELP: p_d = fld_n;
        K_SELX: x_d = fld_n;
        K_MARK: begin
          t_d = DW'({x_q, p_q});
          x_d = p_q;
        end
        K_RETE, K_RETD: begin
          p_d  = mem_rdata[SELW-1:0];
          x_d  = mem_rdata[2*SELW-1:SELW];
          ie_d = (kind == K_RETE);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_q  <= '0;
      x_q  <= '0;
      t_q  <= '0;
      ie_q <= 1'b1;
    end else begin
      p_q  <= p_d;
      x_q  <= x_d;
      t_q  <= t_d;
      ie_q <= ie_d;
    end
  end

  // R9
  irq_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> (p_q == SELW'(1)) && (x_q == SELW'(2)) && !ie_q &&
                (t_q == DW'({$past(x_q), $past(p_q)})));
  // R10
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ie_q && !op_valid) |=> ($stable(p_q) && $stable(x_q) && !ie_q));
  // R5
  sel_p_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == K_SELP) |=> (p_q == $past(fld_n)));
  // R6
  mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == K_MARK) |=> (x_q == $past(p_q)) && (t_q == DW'({$past(x_q), $past(p_q)})));
  // R7
  ret_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == K_RETE) |=> ie_q);
  // R7
  dis_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == K_RETD) |=> !ie_q);
endmodule

// File: rtl/dsg_regfile.sv
module dsg_regfile
  import dsg_pkg::*;
#(
  parameter int NREG = 16,
  parameter int DW   = 8,
  localparam int RW   = 2 * DW,
  localparam int SELW = $clog2(NREG),
  localparam int NRD  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  input  logic [DW-1:0]   op_code,
  input  logic [DW-1:0]   d_in,
  output logic [DW-1:0]   d_out,
  output logic            d_out_vld,
  input  logic            irq_req,
  output logic            irq_ack,
  output logic [RW-1:0]   mem_addr,
  output logic            mem_we,
  output logic            mem_re,
  output logic [DW-1:0]   mem_wdata,
  input  logic [DW-1:0]   mem_rdata,
  output logic [RW-1:0]   pc_addr,
  output logic [RW-1:0]   dp_addr,
  output logic [SELW-1:0] sel_p,
  output logic [SELW-1:0] sel_x,
  output logic            ie
);
  localparam int RD_N = 0;
  localparam int RD_X = 1;
  localparam int RD_P = 2;
  localparam int RD_S = 3;
  localparam logic [SELW-1:0] STK_IDX = SELW'(2);

  logic rst_meta, rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_n_s  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_n_s  <= rst_meta;
    end
  end

  op_kind_e                   kind;
  logic [SELW-1:0]            fld_n;
  logic [DW-1:0]              t_q;
  logic [NRD-1:0][SELW-1:0]   rd_idx;
  logic [NRD-1:0][RW-1:0]     rd_val;
  logic                       wr_en;
  logic [SELW-1:0]            wr_idx;
  logic [RW-1:0]              wr_val;
  logic [RW-1:0]              r_n, r_x, r_s;

  dsg_decode #(.OPW(DW), .SELW(SELW)) u_dec (
    .op_valid (op_valid),
    .op_code  (op_code),
    .kind     (kind),
    .fld_n    (fld_n)
  );

  dsg_ctrl #(.SELW(SELW), .DW(DW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .op_valid  (op_valid),
    .kind      (kind),
    .fld_n     (fld_n),
    .irq_req   (irq_req),
    .mem_rdata (mem_rdata),
    .p_q       (sel_p),
    .x_q       (sel_x),
    .t_q       (t_q),
    .ie_q      (ie),
    .irq_ack   (irq_ack)
  );

  assign rd_idx[RD_N] = fld_n;
  assign rd_idx[RD_X] = sel_x;
  assign rd_idx[RD_P] = sel_p;
  assign rd_idx[RD_S] = STK_IDX;

  dsg_bank #(.NREG(NREG), .RW(RW), .NRD(NRD)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .wr_en  (wr_en),
    .wr_idx (wr_idx),
    .wr_val (wr_val),
    .rd_idx (rd_idx),
    .rd_val (rd_val)
  );

  assign r_n     = rd_val[RD_N];
  assign r_x     = rd_val[RD_X];
  assign r_s     = rd_val[RD_S];
  assign pc_addr = rd_val[RD_P];
  assign dp_addr = r_x;

  always_comb begin
    wr_en     = 1'b0;
    wr_idx    = fld_n;
    wr_val    = r_n;
    d_out     = '0;
    d_out_vld = 1'b0;
    mem_addr  = '0;
    mem_we    = 1'b0;
    mem_re    = 1'b0;
    mem_wdata = '0;
    case (kind)
      K_INC:   begin wr_en = 1'b1; wr_val = r_n + RW'(1); end
      K_DEC:   begin wr_en = 1'b1; wr_val = r_n - RW'(1); end
      K_INCX:  begin wr_en = 1'b1; wr_idx = sel_x; wr_val = r_x + RW'(1); end
      K_GETLO: begin d_out_vld = 1'b1; d_out = r_n[DW-1:0]; end
      K_GETHI: begin d_out_vld = 1'b1; d_out = r_n[RW-1:DW]; end
      K_PUTLO: begin wr_en = 1'b1; wr_val = {r_n[RW-1:DW], d_in}; end
      K_PUTHI: begin wr_en = 1'b1; wr_val = {d_in, r_n[DW-1:0]}; end
      K_MARK: begin
        mem_we    = 1'b1;
        mem_addr  = r_s;
        mem_wdata = DW'({sel_x, sel_p});
        wr_en     = 1'b1;
        wr_idx    = STK_IDX;
        wr_val    = r_s - RW'(1);
      end
      K_RETE, K_RETD: begin
        mem_re   = 1'b1;
        mem_addr = r_x;
        wr_en    = 1'b1;
        wr_idx   = sel_x;
        wr_val   = r_x + RW'(1);
      end
      K_SAVE: begin
        mem_we    = 1'b1;
        mem_addr  = r_x;
        mem_wdata = t_q;
      end
      default: ;
    endcase
  end

  // R2
  incx_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (op_valid && op_code == DW'('h60)) |=> (dp_addr == RW'($past(dp_addr) + RW'(1))));
  // R6
  mark_stack_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (op_valid && op_code == DW'('h79) && sel_p != STK_IDX && sel_x != STK_IDX)
      |=> $stable(sel_p));
  // R11
  idle_mem_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !op_valid |-> !(mem_we || mem_re || d_out_vld));
endmodule

// File: tb/sim_dsg_regfile.sv
module sim_dsg_regfile;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid;
  logic [7:0]  op_code, d_in, d_out, mem_wdata, mem_rdata;
  logic        d_out_vld, irq_req, irq_ack, mem_we, mem_re, ie;
  logic [15:0] mem_addr, pc_addr, dp_addr;
  logic [3:0]  sel_p, sel_x;

  always #4 clk = ~clk;

  dsg_regfile u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .d_in(d_in), .d_out(d_out), .d_out_vld(d_out_vld), .irq_req(irq_req),
    .irq_ack(irq_ack), .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .pc_addr(pc_addr),
    .dp_addr(dp_addr), .sel_p(sel_p), .sel_x(sel_x), .ie(ie)
  );

  logic [7:0] tmem [256];
  assign mem_rdata = tmem[mem_addr[7:0]];
  always @(posedge clk) if (mem_we) tmem[mem_addr[7:0]] <= mem_wdata;

  logic [15:0] m_r [16];
  logic [3:0]  m_p, m_x;
  logic [7:0]  m_t;
  logic        m_ie;
  int checks = 0;
  int fails  = 0;

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic string req_of(input bit v, input logic [7:0] op);
    if (!v) return m_ie ? "R9" : "R10";
    case (op[7:4])
      4'h1, 4'h2: return "R2";
      4'h6: return (op[3:0] == 0) ? "R2" : "R11";
      4'h7: begin
        if (op[3:0] == 4'h9) return "R6";
        if (op[3:0] <= 4'h1) return "R7";
        if (op[3:0] == 4'h8) return "R8";
        return "R11";
      end
      4'h8, 4'h9: return "R3";
      4'hA, 4'hB: return "R4";
      4'hD, 4'hE: return "R5";
      default: return "R11";
    endcase
  endfunction

  task automatic step(input bit v, input logic [7:0] op, input logic [7:0] din, input bit irq);
    logic e_dv, e_we, e_re, e_ack;
    logic [7:0] e_do, e_wd, val;
    logic [15:0] e_addr;
    logic [3:0] n;
    string req;
    @(negedge clk);
    op_valid = v; op_code = op; d_in = din; irq_req = irq;
    #1;
    req = req_of(v, op);
    if (v && irq) req = "R10";
    e_dv = 0; e_we = 0; e_re = 0; e_ack = 0; e_do = 0; e_wd = 0; e_addr = 0;
    n = op[3:0];
    if (v) begin
      case (op[7:4])
        4'h1: m_r[n] = m_r[n] + 16'd1;
        4'h2: m_r[n] = m_r[n] - 16'd1;
        4'h6: if (n == 0) m_r[m_x] = m_r[m_x] + 16'd1;
        4'h7: begin
          if (n <= 4'h1) begin
            e_re = 1; e_addr = m_r[m_x]; val = tmem[e_addr[7:0]];
            m_r[m_x] = m_r[m_x] + 16'd1;
            m_x = val[7:4]; m_p = val[3:0]; m_ie = (n == 0);
          end else if (n == 4'h8) begin
            e_we = 1; e_addr = m_r[m_x]; e_wd = m_t;
          end else if (n == 4'h9) begin
            e_we = 1; e_addr = m_r[2]; e_wd = {m_x, m_p};
            m_t = {m_x, m_p}; m_x = m_p; m_r[2] = m_r[2] - 16'd1;
          end
        end
        4'h8: begin e_dv = 1; e_do = m_r[n][7:0]; end
        4'h9: begin e_dv = 1; e_do = m_r[n][15:8]; end
        4'hA: m_r[n][7:0] = din;
        4'hB: m_r[n][15:8] = din;
        4'hD: m_p = n;
        4'hE: m_x = n;
        default: ;
      endcase
    end else if (irq && m_ie) begin
      e_ack = 1; m_t = {m_x, m_p}; m_p = 4'd1; m_x = 4'd2; m_ie = 0;
    end
    chk(req, "d_out_vld", 16'(d_out_vld), 16'(e_dv));
    if (e_dv) chk(req, "d_out", 16'(d_out), 16'(e_do));
    chk(req, "mem_we", 16'(mem_we), 16'(e_we));
    chk(req, "mem_re", 16'(mem_re), 16'(e_re));
    if (e_we || e_re) chk(req, "mem_addr", mem_addr, e_addr);
    if (e_we) chk(req, "mem_wdata", 16'(mem_wdata), 16'(e_wd));
    chk(req, "irq_ack", 16'(irq_ack), 16'(e_ack));
    @(posedge clk); #1;
    chk(req, "pc_addr", pc_addr, m_r[m_p]);
    chk(req, "dp_addr", dp_addr, m_r[m_x]);
    chk(req, "sel_p", 16'(sel_p), 16'(m_p));
    chk(req, "sel_x", 16'(sel_x), 16'(m_x));
    chk(req, "ie", 16'(ie), 16'(m_ie));
  endtask

  task automatic put16(input logic [3:0] r, input logic [15:0] v);
    step(1, {4'hA, r}, v[7:0], 0);
    step(1, {4'hB, r}, v[15:8], 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    report();
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) tmem[i] = 8'(i * 7 + 3);
    tmem[8'h3F] = 8'h3A;
    for (int i = 0; i < 16; i++) m_r[i] = 16'h0;
    m_p = 0; m_x = 0; m_t = 0; m_ie = 1;
    rst_n = 0; op_valid = 0; op_code = 0; d_in = 0; irq_req = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1", "pc_addr", pc_addr, 16'h0);
    chk("R1", "dp_addr", dp_addr, 16'h0);
    chk("R1", "sel_p", 16'(sel_p), 16'h0);
    chk("R1", "ie", 16'(ie), 16'h1);
    step(1, 8'h8F, 8'h00, 0);                    // R1: register 15 reads zero
    // R4 / R2 / R3: byte puts, carry and wrap
    put16(4'h3, 16'h12FF);
    step(1, 8'h13, 8'h00, 0);
    step(1, 8'h93, 8'h00, 0);
    step(1, 8'h83, 8'h00, 0);
    put16(4'h4, 16'hFFFF);
    step(1, 8'h14, 8'h00, 0);
    step(1, 8'h84, 8'h00, 0);
    step(1, 8'h25, 8'h00, 0);
    step(1, 8'h95, 8'h00, 0);
    // R5 / R2: selects and data-pointer increment
    step(1, 8'hE3, 8'h00, 0);
    step(1, 8'h60, 8'h00, 0);
    step(1, 8'hD5, 8'h00, 0);
    // R6 mark, R8 save
    put16(4'h2, 16'h0040);
    step(1, 8'hE7, 8'h00, 0);
    step(1, 8'h79, 8'h00, 0);
    step(1, 8'h78, 8'h00, 0);
    // R11 ignored opcodes
    step(1, 8'h00, 8'h55, 0);
    step(1, 8'h61, 8'h55, 0);
    step(1, 8'hC4, 8'h55, 0);
    step(1, 8'hF5, 8'h55, 0);
    step(1, 8'h72, 8'h55, 0);
    // R10 request during an opcode, R9 acceptance, R10 held while masked
    step(1, 8'hC4, 8'h00, 1);
    step(0, 8'h00, 8'h00, 1);
    step(0, 8'h00, 8'h00, 1);
    step(0, 8'h00, 8'h00, 1);
    step(1, 8'h78, 8'h00, 1);                    // R8: latch after interrupt
    // R7 return unmasks, held request then taken
    step(1, 8'h70, 8'h00, 1);
    step(0, 8'h00, 8'h00, 1);
    step(1, 8'h71, 8'h00, 0);                    // R7 disable form
    step(0, 8'h00, 8'h00, 1);
    step(1, 8'h70, 8'h00, 0);
    // mixed random traffic
    for (int i = 0; i < 3000; i++)
      step(($urandom % 4) != 0, 8'($urandom), 8'($urandom), ($urandom % 8) == 0);
    report();
    $finish;
  end
endmodule